// File: doc/BRIEF.md
# Multi-Queue Interrupt Vector Router

The router gathers interrupt vectors from three kinds of producer: a set of channels, one port handler and one system-function source. Each producer supplies a vector together with the index of the queue it wants. One request is accepted per clock. The router pushes the accepted vector into one of eight small FIFOs, which are the interrupt queues. The last queue is reserved for urgent traffic. Software can mark any queue with a per-queue redirect bit. A channel vector aimed at a marked queue is then steered into the urgent queue. Port and system vectors are never steered.

A single level interrupt output is raised while any queue has pending, unacknowledged traffic. The host uses a small register port to do the following:
- read a status word showing pending queues and overflowed queues;
- clear those bits by writing ones to them;
- program the redirect mask and the enables for the port and system sources;
- pop vectors from a queue by reading that queue's address.

The port and system sources are disabled out of reset. Channels need no enable.

Top module: `ivr_router`

## Requirements
- R1: An accepted vector is pushed into the queue it names. Reading address 8+q pops queue q in arrival order.
- R2: A channel vector whose requested queue q has bit q of the redirect mask (address 2) set goes to queue 7. With that bit clear, it goes to queue q.
- R3: Port and system vectors go to their requested queue whatever the redirect mask holds.
- R4: After reset the source-enable register (address 3; bit 0 port, bit 1 system) is 0. A disabled port or system request is never granted and queues nothing. Once its bit is set, the same request is accepted.
- R5: At most one request is granted per cycle, in the fixed order system, port, then channels from index 0 upward. A grant is combinational from the request, and the vector is taken at the next rising edge.
- R6: Status bit q (address 0, bits 7:0) sets on the edge that pushes a vector into queue q. Writing 1 to bit q at address 1 clears it, and writing 0 leaves it. A push and a clear in the same cycle leave the bit set.
- R7: `irq` is high exactly while some status bit is set. It rises in the cycle after a push and falls in the cycle after the last set bit is cleared.
- R8: A vector aimed at a full queue (16 entries) is dropped and sets the sticky overflow bit 16+q of the status word. Writing 1 to bit 16+q at address 1 clears it.
- R9: Read data appears on `host_rdata` in the cycle after `host_rd`. Popping an empty queue returns 0.
- R10: After reset the status word, the redirect mask and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | N_CH | Channel requests, held until granted |
| ch_vec | input | N_CH*VEC_W | Channel vectors, channel i in slice i |
| ch_queue | input | N_CH*QI_W | Requested queue per channel |
| ch_gnt | output | N_CH | Channel grants |
| port_req | input | 1 | Port handler request |
| port_vec | input | VEC_W | Port handler vector |
| port_queue | input | QI_W | Port handler queue |
| port_gnt | output | 1 | Port handler grant |
| sys_req | input | 1 | System source request |
| sys_vec | input | VEC_W | System source vector |
| sys_queue | input | QI_W | System source queue |
| sys_gnt | output | 1 | System source grant |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops at queue addresses) |
| host_addr | input | QI_W+1 | Register address |
| host_wdata | input | VEC_W | Write data |
| host_rdata | output | VEC_W | Read data, one cycle after the read |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume three things about the inputs:
- a source keeps its request stable until it sees its grant;
- the host never reads and writes in the same cycle;
- `host_wdata` is meaningful only while `host_wr` is high.

The bench respects all three. It changes inputs only at falling edges and drops each request on the falling edge that follows its grant. It drives one host strobe at a time.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ACK    = 1;
  localparam int ADDR_HPMASK = 2;
  localparam int ADDR_SRCEN  = 3;
  localparam int OVF_LSB     = 16;
endpackage

// File: rtl/ivr_arb.sv
module ivr_arb #(
  parameter int N_CH = 4,
  localparam int CI_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            sys_req,
  input  logic            port_req,
  input  logic [N_CH-1:0] ch_req,
  output logic            sys_gnt,
  output logic            port_gnt,
  output logic [N_CH-1:0] ch_gnt,
  output logic [CI_W-1:0] ch_idx,
  output logic            any_gnt
);
  logic taken;
  always_comb begin
    sys_gnt  = sys_req;
    port_gnt = port_req & ~sys_req;
    taken    = sys_req | port_req;
    ch_gnt   = '0;
    ch_idx   = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch_req[i] && !taken) begin
        ch_gnt[i] = 1'b1;
        ch_idx    = CI_W'(i);
        taken     = 1'b1;
      end
    end
    any_gnt = taken;
  end
endmodule

// File: rtl/ivr_fifo.sv
module ivr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic [W-1:0]  rd_q;
  logic          rd_empty_q;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0; rd_empty_q <= 1'b1;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (pop) rd_empty_q <= empty;
    end
  end

  assign dout = rd_empty_q ? '0 : rd_q;
endmodule

// File: rtl/ivr_router.sv
module ivr_router #(
  parameter int N_CH    = 4,
  parameter int VEC_W   = 32,
  parameter int Q_NUM   = 8,
  parameter int Q_DEPTH = 16,
  localparam int QI_W   = $clog2(Q_NUM),
  localparam int ADDR_W = QI_W + 1,
  localparam int CI_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int HP_Q   = Q_NUM - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_CH-1:0]        ch_req,
  input  logic [N_CH*VEC_W-1:0]  ch_vec,
  input  logic [N_CH*QI_W-1:0]   ch_queue,
  output logic [N_CH-1:0]        ch_gnt,
  input  logic                   port_req,
  input  logic [VEC_W-1:0]       port_vec,
  input  logic [QI_W-1:0]        port_queue,
  output logic                   port_gnt,
  input  logic                   sys_req,
  input  logic [VEC_W-1:0]       sys_vec,
  input  logic [QI_W-1:0]        sys_queue,
  output logic                   sys_gnt,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic [VEC_W-1:0]       host_wdata,
  output logic [VEC_W-1:0]       host_rdata,
  output logic                   irq
);
  import ivr_pkg::*;

  logic             port_en_q, sys_en_q;
  logic [Q_NUM-1:0] hpmask_q, pending_q, ovf_q;
  logic [CI_W-1:0]  ch_idx;
  logic             any_gnt, from_ch, push_ok, drop;
  logic [VEC_W-1:0] sel_vec;
  logic [QI_W-1:0]  sel_q, tgt;
  logic [Q_NUM-1:0] q_full, q_push, q_pop, tgt_hot;
  logic [VEC_W-1:0] q_dout [Q_NUM];
  logic             ack_hit;
  logic [VEC_W-1:0] stat_w, rd_reg;
  logic             rd_is_q;
  logic [QI_W-1:0]  rd_idx;
  logic             unused_ok;

  assign unused_ok = ^host_wdata;

  ivr_arb #(.N_CH(N_CH)) u_arb (
    .sys_req (sys_req & sys_en_q),
    .port_req(port_req & port_en_q),
    .ch_req  (ch_req),
    .sys_gnt (sys_gnt),
    .port_gnt(port_gnt),
    .ch_gnt  (ch_gnt),
    .ch_idx  (ch_idx),
    .any_gnt (any_gnt)
  );

  always_comb begin
    from_ch = 1'b0;
    if (sys_gnt) begin
      sel_vec = sys_vec;  sel_q = sys_queue;
    end else if (port_gnt) begin
      sel_vec = port_vec; sel_q = port_queue;
    end else begin
      sel_vec = ch_vec[int'(ch_idx)*VEC_W +: VEC_W];
      sel_q   = ch_queue[int'(ch_idx)*QI_W +: QI_W];
      from_ch = 1'b1;
    end
    tgt = (from_ch && hpmask_q[sel_q]) ? QI_W'(HP_Q) : sel_q;
  end

  assign push_ok = any_gnt & ~q_full[tgt];
  assign drop    = any_gnt &  q_full[tgt];
  assign ack_hit = host_wr && (host_addr == ADDR_W'(ADDR_ACK));

  for (genvar q = 0; q < Q_NUM; q++) begin : g_q
    assign tgt_hot[q] = (tgt == QI_W'(q));
    assign q_push[q]  = push_ok & tgt_hot[q];
    assign q_pop[q]   = host_rd & host_addr[QI_W] & (host_addr[QI_W-1:0] == QI_W'(q));
    ivr_fifo #(.W(VEC_W), .DEPTH(Q_DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(q_push[q]), .din(sel_vec),
      .pop(q_pop[q]), .dout(q_dout[q]), .full(q_full[q]), .empty()
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_en_q <= 1'b0; sys_en_q <= 1'b0;
      hpmask_q  <= '0;   pending_q <= '0; ovf_q <= '0;
    end else begin
      pending_q <= (pending_q & ~(ack_hit ? host_wdata[Q_NUM-1:0] : '0))
                 | (push_ok ? tgt_hot : '0);
      ovf_q     <= (ovf_q & ~(ack_hit ? host_wdata[OVF_LSB +: Q_NUM] : '0))
                 | (drop ? tgt_hot : '0);
      if (host_wr && host_addr == ADDR_W'(ADDR_HPMASK)) hpmask_q <= host_wdata[Q_NUM-1:0];
      if (host_wr && host_addr == ADDR_W'(ADDR_SRCEN)) begin
        port_en_q <= host_wdata[0];
        sys_en_q  <= host_wdata[1];
      end
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[Q_NUM-1:0]        = pending_q;
    stat_w[OVF_LSB +: Q_NUM] = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_is_q <= 1'b0; rd_idx <= '0; rd_reg <= '0;
    end else if (host_rd) begin
      rd_is_q <= host_addr[QI_W];
      rd_idx  <= host_addr[QI_W-1:0];
      if (host_addr == ADDR_W'(ADDR_STATUS))      rd_reg <= stat_w;
      else if (host_addr == ADDR_W'(ADDR_HPMASK)) rd_reg <= VEC_W'(hpmask_q);
      else if (host_addr == ADDR_W'(ADDR_SRCEN))  rd_reg <= VEC_W'({sys_en_q, port_en_q});
      else                                        rd_reg <= '0;
    end
  end

  assign host_rdata = rd_is_q ? q_dout[rd_idx] : rd_reg;
  assign irq        = |pending_q;
endmodule

// File: rtl/ivr_router_chk.sv
module ivr_router_chk #(
  parameter int N_CH   = 4,
  parameter int VEC_W  = 32,
  parameter int Q_NUM  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sys_gnt,
  input logic              port_gnt,
  input logic [N_CH-1:0]   ch_gnt,
  input logic              port_en_q,
  input logic              push_ok,
  input logic              irq,
  input logic [Q_NUM-1:0]  pending_q,
  input logic [Q_NUM-1:0]  ovf_q,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [VEC_W-1:0]  host_wdata
);
  logic ack_w;
  assign ack_w = host_wr && (host_addr == ADDR_W'(ivr_pkg::ADDR_ACK));

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sys_gnt, port_gnt, ch_gnt})); // R5
  AST_PORT_MASKED: assert property (@(posedge clk) disable iff (rst)
    !port_en_q |-> !port_gnt); // R4
  AST_IRQ_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> irq); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_w && !push_ok) |=> ((pending_q & $past(host_wdata[Q_NUM-1:0])) == '0)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !ack_w |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R8
  AST_IRQ_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq); // R10
endmodule

bind ivr_router ivr_router_chk #(.N_CH(N_CH), .VEC_W(VEC_W), .Q_NUM(Q_NUM), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sys_gnt(sys_gnt), .port_gnt(port_gnt), .ch_gnt(ch_gnt),
  .port_en_q(port_en_q), .push_ok(push_ok), .irq(irq), .pending_q(pending_q),
  .ovf_q(ovf_q), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata)
);

// File: tb/ivr_router_bench.sv
module ivr_router_bench;
  localparam int NC = 4;
  logic clk = 0, rst = 1;
  logic [NC-1:0] ch_req = '0, ch_gnt;
  logic [NC*32-1:0] ch_vec = '0;
  logic [NC*3-1:0] ch_queue = '0;
  logic port_req = 0, port_gnt, sys_req = 0, sys_gnt;
  logic [31:0] port_vec = '0, sys_vec = '0;
  logic [2:0] port_queue = '0, sys_queue = '0;
  logic host_wr = 0, host_rd = 0;
  logic [3:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  ivr_router u_ivr_router (.*);

  always #5 clk = ~clk;

  localparam int T_N = 7;
  localparam int T_SRC[T_N] = '{2, 2, 1, 0, 2, 2, 2}; // 0 system, 1 port, 2 channel
  localparam int T_CH [T_N] = '{0, 3, 0, 0, 1, 2, 2};
  localparam int T_Q  [T_N] = '{2, 2, 2, 5, 5, 0, 7};
  localparam logic [7:0] T_HP[T_N] = '{8'h00, 8'h04, 8'h04, 8'h20, 8'h00, 8'h01, 8'h00};
  localparam int T_EXP[T_N] = '{2, 7, 2, 5, 5, 7, 7};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = 4'(a); host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_addr = 4'(a);
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic inject(input int src, input int ch, input int q, input logic [31:0] v, output bit g);
    @(negedge clk);
    case (src)
      0: begin sys_req = 1; sys_vec = v; sys_queue = 3'(q); end
      1: begin port_req = 1; port_vec = v; port_queue = 3'(q); end
      default: begin ch_req[ch] = 1; ch_vec[ch*32 +: 32] = v; ch_queue[ch*3 +: 3] = 3'(q); end
    endcase
    #1;
    g = (src == 0) ? sys_gnt : (src == 1) ? port_gnt : ch_gnt[ch];
    @(negedge clk);
    sys_req = 0; port_req = 0; ch_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit g;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(irq == 0, "R10 irq after reset", 32'(irq), 0);
    rd(0, d); chk(d == 0, "R10 status after reset", d, 0);
    rd(2, d); chk(d == 0, "R10 redirect mask after reset", d, 0);
    rd(3, d); chk(d == 0, "R4 source enable after reset", d, 0);
    // R4 masked port and system sources
    inject(1, 0, 1, 32'h1111_0001, g); chk(g == 0, "R4 port not granted while disabled", 32'(g), 0);
    inject(0, 0, 1, 32'h1111_0002, g); chk(g == 0, "R4 system not granted while disabled", 32'(g), 0);
    rd(0, d); chk(d == 0, "R4 nothing pending after masked request", d, 0);
    rd(9, d); chk(d == 0, "R9 empty pop returns zero (R4 queue 1 empty)", d, 0);
    wr(3, 32'h3);
    rd(3, d); chk(d == 3, "R4 source enable readback", d, 3);

    // table walk: R1 R2 R3 R6 R7
    for (int i = 0; i < T_N; i++) begin
      logic [31:0] v;
      v = 32'hA000_0000 + 32'(i);
      wr(2, 32'(T_HP[i]));
      inject(T_SRC[i], T_CH[i], T_Q[i], v, g);
      chk(g == 1, "R5 single request granted", 32'(g), 1);
      chk(irq == 1, "R7 irq after push", 32'(irq), 1);
      rd(0, d); chk(d == (32'h1 << T_EXP[i]), "R6 status bit of target queue", d, 32'h1 << T_EXP[i]);
      rd(8 + T_EXP[i], d); chk(d == v, "R1/R2/R3 vector in expected queue", d, v);
      wr(1, 32'h1 << T_EXP[i]);
      chk(irq == 0, "R7 irq falls after last clear", 32'(irq), 0);
    end
    wr(2, 32'h0);

    // R5 arbitration order, all to queue 4
    @(negedge clk);
    sys_req = 1; sys_vec = 32'hB0; sys_queue = 3'd4;
    port_req = 1; port_vec = 32'hB1; port_queue = 3'd4;
    ch_req = 4'b0110;
    ch_vec[1*32 +: 32] = 32'hB2; ch_queue[1*3 +: 3] = 3'd4;
    ch_vec[2*32 +: 32] = 32'hB3; ch_queue[2*3 +: 3] = 3'd4;
    #1; chk(sys_gnt && !port_gnt && ch_gnt == 0, "R5 system wins", {port_gnt, sys_gnt, 26'b0, ch_gnt}, 32'h4000_0000);
    @(negedge clk); sys_req = 0;
    #1; chk(port_gnt && ch_gnt == 0, "R5 port next", {port_gnt, 27'b0, ch_gnt}, 32'h8000_0000);
    @(negedge clk); port_req = 0;
    #1; chk(ch_gnt == 4'b0010, "R5 lowest channel next", 32'(ch_gnt), 2);
    @(negedge clk); ch_req[1] = 0;
    #1; chk(ch_gnt == 4'b0100, "R5 channel 2 last", 32'(ch_gnt), 4);
    @(negedge clk); ch_req = '0;
    for (int k = 0; k < 4; k++) begin
      rd(12, d); chk(d == 32'hB0 + 32'(k), "R1 queue order follows grant order", d, 32'hB0 + 32'(k));
    end
    rd(12, d); chk(d == 0, "R9 pop after drain returns zero", d, 0);
    wr(1, 32'h10);

    // R6 push and clear in same cycle
    @(negedge clk);
    ch_req[0] = 1; ch_vec[31:0] = 32'hC6; ch_queue[2:0] = 3'd6;
    host_wr = 1; host_addr = 4'd1; host_wdata = 32'h40;
    @(negedge clk); ch_req = '0; host_wr = 0;
    rd(0, d); chk(d == 32'h40, "R6 push beats same-cycle clear", d, 32'h40);
    wr(1, 32'h0);
    rd(0, d); chk(d == 32'h40, "R6 writing zero keeps bit", d, 32'h40);
    wr(1, 32'h40);
    rd(14, d);

    // R8 overflow on queue 3
    for (int k = 0; k < 17; k++) begin
      inject(2, 1, 3, 32'hD00 + 32'(k), g);
    end
    rd(0, d); chk(d == 32'h0008_0008, "R8 overflow and pending set", d, 32'h0008_0008);
    wr(1, 32'h0000_0008);
    rd(0, d); chk(d == 32'h0008_0000, "R8 overflow sticky after pending clear", d, 32'h0008_0000);
    wr(1, 32'h0008_0000);
    rd(0, d); chk(d == 0, "R8 overflow cleared by write one", d, 0);
    rd(11, d); chk(d == 32'hD00, "R8 first vector kept", d, 32'hD00);
    for (int k = 1; k < 16; k++) rd(11, d);
    chk(d == 32'hD0F, "R8 sixteenth vector kept, seventeenth dropped", d, 32'hD0F);
    rd(11, d); chk(d == 0, "R8 dropped vector absent", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule